// File: doc/BRIEF.md
# TDM Frame Offset Aligner

This block sits on the transmit side of an E1 system backplane. It takes a serial data stream, a signaling nibble that changes once per timeslot, a backplane clock and a frame pulse. It recovers where each frame really begins. The frame start trails the pulse by a programmable number of whole timeslots plus a few extra bit periods. The block follows the current timeslot and bit position, shifts in one data bit per bit period, and presents one assembled byte per timeslot. Each byte comes with its signaling nibble, its timeslot index and, when four links are interleaved, its link number.

A single link gives a frame of 32 timeslots (256 bit periods). In multiplexed mode four links are byte-interleaved into 128 timeslots (1024 bit periods). The backplane clock can run at the bit rate or at twice the bit rate. At twice the rate, a configuration bit picks which of the two clock cycles in each bit period samples the inputs. In clock-slave operation the frame pulse comes from the system side. In clock-master operation the block produces the pulse itself from its free-running position counter. All configuration inputs are static levels.

Top module: `tdm_offset_aligner`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `byte_vld_o` and `realign_o` are low and `byte_o` and `ts_idx_o` are zero. With `clk_slave_i`=1, `fp_o` is low.
- R2: Bits are packed with the earliest sampled bit in the MSB (`byte_o[7]`). `byte_vld_o` is high for exactly one cycle: the cycle after the clock edge that samples the eighth bit of a timeslot. `sig_o` holds the value of `sig_i` sampled at that same edge.
- R3: Bit 7 of timeslot 0 (the first bit of the frame) is sampled in bit period `ts_off_i*8 + bit_off_i` after the frame pulse, counted modulo the frame length. Bit periods start at 0 on the pulse cycle. `ts_idx_o` gives the timeslot each byte belongs to.
- R4: With `mux_mode_i`=0 the frame is 256 bit periods. Only the low five bits of `ts_off_i` count. `ts_idx_o` stays in 0..31 and `link_o` is 0.
- R5: With `mux_mode_i`=1 the frame is 1024 bit periods. All seven bits of `ts_off_i` count. `ts_idx_o` runs 0..127 and `link_o` equals `ts_idx_o` modulo 4.
- R6: With `dbl_rate_i`=1 each bit period lasts two clock cycles, and the first of the two is the pulse cycle. `edge_sel_i`=0 samples in the first cycle and `edge_sel_i`=1 in the second. With `dbl_rate_i`=0 every cycle is a bit period and `edge_sel_i` has no effect.
- R7: In slave mode, a pulse that lands where the counter already expects position 0 leaves `realign_o` low. A pulse anywhere else restarts the counter at position 0 and drives `realign_o` high for one cycle, the cycle after the pulse.
- R8: With no further pulses the counter freewheels. A strobe follows every 8 bit periods, and `ts_idx_o` wraps from the last timeslot back to 0.
- R9: With `clk_slave_i`=0, `fp_i` is ignored and `realign_o` stays low. `fp_o` is high for one cycle at position 0 of every frame. The frame lasts frame-length × (1 or 2) cycles, and data is aligned to that pulse exactly as to an external one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Backplane clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_slave_i | input | 1 | 1: frame pulse from system side; 0: generated internally |
| mux_mode_i | input | 1 | 1: four interleaved links; 0: single link |
| dbl_rate_i | input | 1 | 1: clock runs at twice the bit rate |
| edge_sel_i | input | 1 | Sampling cycle within a bit period at double rate |
| ts_off_i | input | 7 | Timeslot offset from pulse to frame start |
| bit_off_i | input | 3 | Extra bit-period offset from pulse to frame start |
| fp_i | input | 1 | Frame pulse from system side |
| data_i | input | 1 | Serial data |
| sig_i | input | 4 | Signaling nibble for the current timeslot |
| fp_o | output | 1 | Generated frame pulse in master mode |
| realign_o | output | 1 | One-cycle flag after a misplaced pulse |
| byte_vld_o | output | 1 | Assembled-timeslot strobe |
| byte_o | output | 8 | Assembled data byte, first bit in MSB |
| sig_o | output | 4 | Signaling nibble of the timeslot |
| ts_idx_o | output | 7 | Timeslot index of the byte |
| link_o | output | 2 | Link number in multiplexed mode |

## Verification
A strobe shows up one cycle after the edge that samples the last bit of its timeslot. `realign_o` shows up one cycle after the pulse cycle. `fp_o` is driven directly from the position register, so it is valid during the position-0 cycle itself. The bench drives every input at the falling edge. It works out, for each driven cycle, whether that cycle samples and which timeslot and bit it carries. It compares strobe, realign and pulse outputs at the following falling edge, so each result is read exactly one register stage after the edge that produces it. Byte contents are compared only once eight samples have been taken since the latest pulse, because earlier bits belong to the previous run.

// File: rtl/tdm_align_pkg.sv
package tdm_align_pkg;
  localparam int unsigned TS_PER_LINK = 32;
  localparam int unsigned NUM_LINKS   = 4;
  localparam int unsigned BITS_PER_TS = 8;
  localparam int unsigned SIG_W       = 4;
  localparam int unsigned TS_W        = $clog2(TS_PER_LINK * NUM_LINKS);
  localparam int unsigned TS_NM_W     = $clog2(TS_PER_LINK);
  localparam int unsigned BIT_W       = $clog2(BITS_PER_TS);
  localparam int unsigned LINK_W      = $clog2(NUM_LINKS);
  localparam int unsigned POS_W       = TS_W + BIT_W;
endpackage

// File: rtl/tdm_pos_ctr.sv
module tdm_pos_ctr #(
  parameter int unsigned TS_W    = 7,
  parameter int unsigned TS_NM_W = 5,
  parameter int unsigned BIT_W   = 3,
  localparam int unsigned POS_W  = TS_W + BIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slave_i,
  input  logic             mux_i,
  input  logic             dbl_i,
  input  logic             edge_i,
  input  logic [TS_W-1:0]  ts_off_i,
  input  logic [BIT_W-1:0] bit_off_i,
  input  logic             fp_i,
  output logic             samp_o,
  output logic [POS_W-1:0] rel_o,
  output logic             realign_o,
  output logic             fp_o
);
  localparam logic [POS_W-1:0] MASK_MUX  = '1;
  localparam logic [POS_W-1:0] MASK_NM   = POS_W'((1 << (TS_NM_W + BIT_W)) - 1);
  localparam logic [TS_W-1:0]  TS_NM_MSK = TS_W'((1 << TS_NM_W) - 1);

  logic [POS_W-1:0] pos_q, pos_d, cur_pos, pos_mask, off;
  logic [TS_W-1:0]  ts_eff;
  logic             ph_q, ph_d, cur_ph, fp_act, adv, realign_q;

  always_comb begin
    fp_act   = slave_i & fp_i;
    cur_pos  = fp_act ? '0 : pos_q;
    cur_ph   = fp_act ? 1'b0 : ph_q;
    pos_mask = mux_i ? MASK_MUX : MASK_NM;
    // double rate: advance position after the second cycle of a bit period
    adv      = ~dbl_i | cur_ph;
    pos_d    = adv ? ((cur_pos + POS_W'(1)) & pos_mask) : cur_pos;
    ph_d     = dbl_i & ~cur_ph;
    samp_o   = ~dbl_i | (cur_ph == edge_i);
    ts_eff   = mux_i ? ts_off_i : (ts_off_i & TS_NM_MSK);
    off      = {ts_eff, bit_off_i};
    rel_o    = (cur_pos - off) & pos_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= '0;
      ph_q      <= 1'b0;
      realign_q <= 1'b0;
    end else begin
      pos_q     <= pos_d;
      ph_q      <= ph_d;
      realign_q <= fp_act & ((pos_q != '0) | ph_q);
    end
  end

  assign realign_o = realign_q;
  assign fp_o      = ~slave_i & (pos_q == '0) & ~ph_q;
endmodule

// File: rtl/tdm_byte_asm.sv
module tdm_byte_asm #(
  parameter int unsigned TS_W   = 7,
  parameter int unsigned BIT_W  = 3,
  parameter int unsigned LINK_W = 2,
  parameter int unsigned SIG_W  = 4,
  localparam int unsigned POS_W  = TS_W + BIT_W,
  localparam int unsigned BYTE_W = 1 << BIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_i,
  input  logic [POS_W-1:0]  rel_i,
  input  logic              data_i,
  input  logic [SIG_W-1:0]  sig_i,
  input  logic              mux_i,
  output logic              vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [SIG_W-1:0]  sig_o,
  output logic [TS_W-1:0]   ts_o,
  output logic [LINK_W-1:0] link_o
);
  logic [BYTE_W-2:0] sr_q;
  logic [TS_W-1:0]   ts_cur;
  logic [LINK_W-1:0] link_cur;
  logic              last;

  assign ts_cur   = rel_i[POS_W-1:BIT_W];
  assign link_cur = mux_i ? ts_cur[LINK_W-1:0] : '0;
  assign last     = samp_i & (&rel_i[BIT_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      vld_o  <= 1'b0;
      byte_o <= '0;
      sig_o  <= '0;
      ts_o   <= '0;
      link_o <= '0;
    end else begin
      vld_o <= last;
      if (samp_i) sr_q <= {sr_q[BYTE_W-3:0], data_i};
      if (last) begin
        byte_o <= {sr_q, data_i};
        sig_o  <= sig_i;
        ts_o   <= ts_cur;
        link_o <= link_cur;
      end
    end
  end
endmodule

// File: rtl/tdm_offset_aligner.sv
module tdm_offset_aligner
  import tdm_align_pkg::*;
#(
  parameter int unsigned P_TS_PER_LINK = TS_PER_LINK,
  parameter int unsigned P_NUM_LINKS   = NUM_LINKS,
  parameter int unsigned P_BITS_PER_TS = BITS_PER_TS,
  parameter int unsigned P_SIG_W       = SIG_W,
  localparam int unsigned L_TS_W    = $clog2(P_TS_PER_LINK * P_NUM_LINKS),
  localparam int unsigned L_TS_NM_W = $clog2(P_TS_PER_LINK),
  localparam int unsigned L_BIT_W   = $clog2(P_BITS_PER_TS),
  localparam int unsigned L_LINK_W  = $clog2(P_NUM_LINKS),
  localparam int unsigned L_POS_W   = L_TS_W + L_BIT_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clk_slave_i,
  input  logic                     mux_mode_i,
  input  logic                     dbl_rate_i,
  input  logic                     edge_sel_i,
  input  logic [L_TS_W-1:0]        ts_off_i,
  input  logic [L_BIT_W-1:0]       bit_off_i,
  input  logic                     fp_i,
  input  logic                     data_i,
  input  logic [P_SIG_W-1:0]       sig_i,
  output logic                     fp_o,
  output logic                     realign_o,
  output logic                     byte_vld_o,
  output logic [P_BITS_PER_TS-1:0] byte_o,
  output logic [P_SIG_W-1:0]       sig_o,
  output logic [L_TS_W-1:0]        ts_idx_o,
  output logic [L_LINK_W-1:0]      link_o
);
  logic               samp;
  logic [L_POS_W-1:0] rel;

  tdm_pos_ctr #(
    .TS_W   (L_TS_W),
    .TS_NM_W(L_TS_NM_W),
    .BIT_W  (L_BIT_W)
  ) u_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .slave_i  (clk_slave_i),
    .mux_i    (mux_mode_i),
    .dbl_i    (dbl_rate_i),
    .edge_i   (edge_sel_i),
    .ts_off_i (ts_off_i),
    .bit_off_i(bit_off_i),
    .fp_i     (fp_i),
    .samp_o   (samp),
    .rel_o    (rel),
    .realign_o(realign_o),
    .fp_o     (fp_o)
  );

  tdm_byte_asm #(
    .TS_W  (L_TS_W),
    .BIT_W (L_BIT_W),
    .LINK_W(L_LINK_W),
    .SIG_W (P_SIG_W)
  ) u_asm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .samp_i(samp),
    .rel_i (rel),
    .data_i(data_i),
    .sig_i (sig_i),
    .mux_i (mux_mode_i),
    .vld_o (byte_vld_o),
    .byte_o(byte_o),
    .sig_o (sig_o),
    .ts_o  (ts_idx_o),
    .link_o(link_o)
  );
endmodule

// File: rtl/tdm_offset_aligner_chk.sv
module tdm_offset_aligner_chk
  import tdm_align_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clk_slave_i,
  input logic              mux_mode_i,
  input logic              fp_i,
  input logic              fp_o,
  input logic              realign_o,
  input logic              byte_vld_o,
  input logic [TS_W-1:0]   ts_idx_o,
  input logic [LINK_W-1:0] link_o
);
  // R2
  strobe_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);

  // R7
  realign_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_o |-> $past(fp_i && clk_slave_i));

  // R9
  master_pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_o |=> !fp_o);

  // R4
  single_link_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_o && $past(!mux_mode_i)) |-> (link_o == '0 && ts_idx_o < TS_W'(TS_PER_LINK)));
endmodule

bind tdm_offset_aligner tdm_offset_aligner_chk u_chk (.*);

// File: tb/tdm_offset_aligner_test.sv
`timescale 1ns/1ps
module tdm_offset_aligner_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slave = 1'b1, mux = 1'b0, dbl = 1'b0, edg = 1'b0;
  logic [6:0] ts_off = '0;
  logic [2:0] bit_off = '0;
  logic       fp = 1'b0, data = 1'b0;
  logic [3:0] sig = '0;
  logic       fp_o, realign, vld;
  logic [7:0] byte_q;
  logic [3:0] sig_q;
  logic [6:0] ts_q;
  logic [1:0] link_q;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tdm_offset_aligner uut (
    .clk_i(clk), .rst_ni(rst_n), .clk_slave_i(slave), .mux_mode_i(mux),
    .dbl_rate_i(dbl), .edge_sel_i(edg), .ts_off_i(ts_off), .bit_off_i(bit_off),
    .fp_i(fp), .data_i(data), .sig_i(sig), .fp_o(fp_o), .realign_o(realign),
    .byte_vld_o(vld), .byte_o(byte_q), .sig_o(sig_q), .ts_idx_o(ts_q), .link_o(link_q)
  );

  function automatic logic [7:0] pat(int t, int s);
    return 8'(t * 29 + s * 7 + 3);
  endfunction

  function automatic logic [3:0] snib(int t, int s);
    return 4'(t ^ s);
  endfunction

  task automatic chk(input bit ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!vld && !realign && byte_q == 0 && ts_q == 0 && !fp_o, "R1",
        $sformatf("in reset vld=%0b rl=%0b byte=%0h ts=%0d fp_o=%0b exp all 0", vld, realign, byte_q, ts_q, fp_o));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!vld && !realign && byte_q == 0 && !fp_o, "R1",
        $sformatf("after reset vld=%0b rl=%0b byte=%0h fp_o=%0b exp all 0", vld, realign, byte_q, fp_o));
  endtask

  // generic directed scenario; checks strobes, realign and pulse output
  task automatic t_stream(input bit master, input bit m, input bit d, input bit e,
                          input int tso, input int bo, input int ncyc, input int fp_per,
                          input string tag, input int seed);
    int len, cpp, cpf, off, last, ns;
    bit found;
    len = m ? 1024 : 256;
    cpp = d ? 2 : 1;
    cpf = len * cpp;
    off = (m ? tso : (tso & 31)) * 8 + bo;
    slave = !master; mux = m; dbl = d; edg = e;
    ts_off = 7'(tso); bit_off = 3'(bo);
    fp = 1'b0;
    if (master) begin
      found = 1'b0;
      for (int k = 0; k < cpf + 4 && !found; k++) begin
        @(negedge clk);
        if (fp_o) found = 1'b1;
      end
      chk(found, "R9", $sformatf("no fp_o within %0d cycles, act 0 exp 1", cpf + 4));
    end
    last = 0; ns = 0;
    for (int i = 0; i < ncyc; i++) begin
      int c, q, ph, rel, t, b;
      bit pulse, samp, exp_v, exp_r, chk_r, exp_fo;
      pulse = !master && (i == 0 || (fp_per > 0 && i % fp_per == 0));
      exp_r = pulse && ((i - last) % cpf != 0);
      chk_r = pulse && i > 0;
      if (pulse) begin last = i; ns = 0; end
      c = i - last;
      exp_fo = master && (c % cpf == 0);
      if (exp_fo || fp_o != exp_fo)
        chk(fp_o == exp_fo, "R9", $sformatf("cyc %0d fp_o act %0b exp %0b", c, fp_o, exp_fo));
      q = c / cpp; ph = c % cpp;
      rel = ((q % len) - off + len) % len;
      t = rel / 8; b = rel % 8;
      data = pat(t, seed)[7 - b];
      sig = snib(t, seed);
      fp = pulse | (master && (i % 37 == 5));
      samp = !d || (ph == (e ? 1 : 0));
      if (samp) ns++;
      exp_v = samp && b == 7;
      @(negedge clk);
      if (exp_v) begin
        logic [1:0] el;
        el = m ? 2'(t % 4) : 2'b0;
        if (ns >= 8)
          chk(vld && byte_q == pat(t, seed) && sig_q == snib(t, seed) && ts_q == 7'(t) && link_q == el, tag,
              $sformatf("strobe act v=%0b b=%0h s=%0h ts=%0d l=%0d exp v=1 b=%0h s=%0h ts=%0d l=%0d",
                        vld, byte_q, sig_q, ts_q, link_q, pat(t, seed), snib(t, seed), t, el));
        else
          chk(vld, tag, $sformatf("strobe act 0 exp 1 ts %0d", t));
      end else if (vld) begin
        chk(1'b0, tag, $sformatf("spurious strobe act 1 exp 0 ts %0d", ts_q));
      end
      if (chk_r)
        chk(realign == exp_r, "R7", $sformatf("realign act %0b exp %0b at %0d", realign, exp_r, i));
      else if (i > 0 && realign)
        chk(1'b0, "R7", $sformatf("realign act 1 exp 0 at %0d", i));
    end
    fp = 1'b0;
  endtask

  initial begin
    t_reset();
    t_stream(0, 0, 0, 0,   0, 0,  300,   0, "R2", 1);
    t_stream(0, 0, 0, 0,   5, 3,  300,   0, "R3", 2);
    t_stream(0, 0, 0, 0,  40, 7,  300,   0, "R4", 3);
    t_stream(0, 1, 0, 0, 100, 6, 1100,   0, "R5", 4);
    t_stream(0, 1, 0, 0, 127, 7, 1100,   0, "R3", 9);
    t_stream(0, 0, 1, 0,   3, 2,  600,   0, "R6", 5);
    t_stream(0, 0, 1, 1,   3, 2,  600,   0, "R6", 6);
    t_stream(0, 0, 0, 1,   2, 1,  300,   0, "R6", 7);
    t_stream(0, 0, 0, 0,   1, 0,  800, 256, "R7", 8);
    t_stream(0, 0, 0, 0,   1, 0,  500, 100, "R7", 10);
    t_stream(0, 0, 0, 0,  31, 5,  700,   0, "R8", 11);
    t_stream(1, 0, 0, 0,   4, 4,  600,   0, "R9", 12);
    t_stream(1, 1, 1, 1,   9, 1, 2200,   0, "R9", 13);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run incomplete, act timeout exp finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule